// File: doc/BRIEF.md
# Low-Power SDRAM Mode Programming and Burst Column Sequencer

This block sits in the command path of a low-power SDRAM device. It holds two configuration registers, both loaded by a mode-programming command. The main mode register holds burst length, burst ordering, read latency and a write-single option. The extended register, chosen by the bank-address bits, holds the partial-array and temperature-compensated self-refresh fields and the output drive strength. A load is accepted only when the bank-idle status is high and every field holds a legal code. Otherwise the registers keep their values and a one-cycle error pulse is raised.

For every READ or WRITE the block walks the column addresses of the burst, in sequential or interleaved order, starting from the column given with the command. For reads it produces a data-valid strobe delayed by the read latency that was in force when the read was issued. A new READ or WRITE issued during a burst ends the earlier column walk at once. Read beats that were already issued still produce their delayed strobes.

Top module: `sdr_modeseq`

## Requirements
- R1: After reset the drive strength output is 01 (half), both self-refresh outputs are 0, no column, read strobe or error pulse is active, and the main register holds burst length 1, sequential order and read latency 3.
- R2: A load with command code 01 and bank bits 00 writes the main register: burst length code in address bits 2..0 (000, 001, 010, 011 select 1, 2, 4, 8 beats), ordering in bit 3 (0 sequential, 1 interleaved), latency code in bits 6..4 (010 selects 2 cycles, 011 selects 3), write-single in bit 9. The new settings govern commands issued from the next cycle on.
- R3: A load with bank bits 10 writes the extended register: partial-array field from address bits 2..0, temperature field from bits 4..3, drive code from bits 6..5 (00 full, 01 half). These outputs take the new values one cycle after the load.
- R4: A load issued while the bank-idle input is low changes neither register and drives the error output high for exactly the next cycle.
- R5: A load holding a reserved code is rejected whole, with the same error pulse. The reserved codes are: burst code with bit 2 set, latency code other than 010 or 011, drive code 10 or 11, bank bits 01 or 11.
- R6: A READ (code 10) or WRITE (code 11) sampled at edge n drives the column-valid output for cycles n through n+L-1, with L the burst length. The column-write output shows the command type, and the first column equals the column bits of the address.
- R7: In sequential order, beat k carries the low log2(L) column bits of (start + k) mod L, and the upper bits come from the start column.
- R8: In interleaved order, beat k carries the low log2(L) column bits of the start column XOR k, and the upper bits come from the start column.
- R9: With write-single set, each WRITE emits exactly one column beat while each READ still emits L beats.
- R10: For a read beat shown after edge n+k, the read-valid output is high after edge n+k+m, with m the latency in force when the READ was issued. Writes produce no read-valid.
- R11: A READ or WRITE issued while a burst is running replaces its remaining column beats, and read beats already issued still produce read-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd | input | 2 | Registered command: 00 none, 01 load, 10 read, 11 write |
| ba | input | 2 | Bank-address bits, selecting the register for a load |
| addr | input | ADDR_W | Address bus: load data or start column |
| banks_idle | input | 1 | High when every bank is idle |
| col_valid | output | 1 | A burst column is being issued this cycle |
| col_addr | output | COL_W | Current burst column |
| col_write | output | 1 | Current burst belongs to a write |
| rd_valid | output | 1 | Read data valid, delayed by the read latency |
| drive_sel | output | 2 | Drive strength code |
| pasr_sel | output | 3 | Partial-array self-refresh code |
| tcsr_sel | output | 2 | Temperature-compensated self-refresh code |
| cfg_err | output | 1 | One-cycle pulse for a rejected load |

## Verification
Two things can fall in the same cycle: the column walk of a new WRITE or READ, and the delayed read-valid strobes of an earlier read still moving through the latency pipe. The bench provokes this by cutting off an eight-beat, latency-3 read with a write after a few beats, and then a read with another read. A scoreboard removes only the column beats that were never issued and keeps the read-valid entries of beats already shown. It then checks, cycle by cycle, that the new burst's columns and the old burst's strobes both appear.

// File: rtl/sdr_modeseq_pkg.sv
package sdr_modeseq_pkg;

   typedef enum logic [1:0] {
      CMD_NOP  = 2'b00,
      CMD_LOAD = 2'b01,
      CMD_RD   = 2'b10,
      CMD_WR   = 2'b11
   } cmd_e;

   typedef struct packed {
      logic [1:0] blog;       // log2 of burst length
      logic       intlv;      // 1 = interleaved ordering
      logic [1:0] lat;        // read latency in cycles (2 or 3)
      logic       wr_single;  // writes are one beat
   } mode_t;

   typedef struct packed {
      logic [2:0] pasr;
      logic [1:0] tcsr;
      logic [1:0] drive;
   } ext_t;

   localparam mode_t MODE_RESET = '{blog: 2'd0, intlv: 1'b0, lat: 2'd3, wr_single: 1'b0};
   localparam ext_t  EXT_RESET  = '{pasr: 3'd0, tcsr: 2'd0, drive: 2'b01};

   localparam logic [1:0] BA_MAIN = 2'b00;
   localparam logic [1:0] BA_EXT  = 2'b10;

   function automatic logic lat_code_ok(input logic [2:0] code);
      return (code == 3'b010) || (code == 3'b011);
   endfunction

endpackage

// File: rtl/sdr_mode_regs.sv
module sdr_mode_regs
   import sdr_modeseq_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int MAX_BL_LOG = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   input  logic              banks_idle,
   output mode_t             mode_q,
   output ext_t              ext_q,
   output logic              err_q
);

   if (ADDR_W < 10) begin : g_bad_addr
      $error("sdr_mode_regs: ADDR_W must reach the write-single bit");
   end
   if (MAX_BL_LOG < 1 || MAX_BL_LOG > 3) begin : g_bad_bl
      $error("sdr_mode_regs: MAX_BL_LOG must be 1..3");
   end

   localparam logic [1:0] BL_MAX_CODE = 2'(MAX_BL_LOG);

   logic main_ok, ext_ok, wr_main, wr_ext, reject;

   always_comb begin
      main_ok = !addr[2] && (addr[1:0] <= BL_MAX_CODE) && lat_code_ok(addr[6:4]);
      ext_ok  = !addr[6];
      wr_main = load_en && banks_idle && (ba == BA_MAIN) && main_ok;
      wr_ext  = load_en && banks_idle && (ba == BA_EXT) && ext_ok;
      reject  = load_en && !(wr_main || wr_ext);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         ext_q  <= EXT_RESET;
         err_q  <= 1'b0;
      end else begin
         err_q <= reject;
         if (wr_main) begin
            mode_q.blog      <= addr[1:0];
            mode_q.intlv     <= addr[3];
            mode_q.lat       <= addr[5:4];
            mode_q.wr_single <= addr[9];
         end
         if (wr_ext) begin
            ext_q.pasr  <= addr[2:0];
            ext_q.tcsr  <= addr[4:3];
            ext_q.drive <= addr[6:5];
         end
      end
   end

endmodule

// File: rtl/sdr_burst_gen.sv
module sdr_burst_gen #(
   parameter int COL_W      = 9,
   parameter int MAX_BL_LOG = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic             go_wr,
   input  logic [COL_W-1:0] go_col,
   input  logic [1:0]       go_blog,
   input  logic             go_intlv,
   input  logic [1:0]       go_lat,
   output logic             col_valid,
   output logic [COL_W-1:0] col_addr,
   output logic             col_write,
   output logic [1:0]       beat_lat
);

   if (COL_W <= MAX_BL_LOG) begin : g_bad_col
      $error("sdr_burst_gen: COL_W must exceed MAX_BL_LOG");
   end

   logic                  active_q, wr_q, intlv_q;
   logic [1:0]            blog_q, lat_q;
   logic [MAX_BL_LOG-1:0] cnt_q, len_mask, sum, low;
   logic [COL_W-1:0]      start_q;
   logic                  last;

   for (genvar b = 0; b < MAX_BL_LOG; b++) begin : g_bit
      assign len_mask[b] = (blog_q > 2'(b));
      assign low[b] = len_mask[b] ? (intlv_q ? (start_q[b] ^ cnt_q[b]) : sum[b])
                                  : start_q[b];
   end

   assign sum  = start_q[MAX_BL_LOG-1:0] + cnt_q;
   assign last = (cnt_q == len_mask);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         wr_q     <= 1'b0;
         intlv_q  <= 1'b0;
         blog_q   <= 2'd0;
         lat_q    <= 2'd3;
         cnt_q    <= '0;
         start_q  <= '0;
      end else if (go) begin
         active_q <= 1'b1;
         wr_q     <= go_wr;
         intlv_q  <= go_intlv;
         blog_q   <= go_blog;
         lat_q    <= go_lat;
         cnt_q    <= '0;
         start_q  <= go_col;
      end else if (active_q) begin
         if (last) active_q <= 1'b0;
         else      cnt_q    <= cnt_q + 1'b1;
      end
   end

   assign col_valid = active_q;
   assign col_write = wr_q;
   assign col_addr  = {start_q[COL_W-1:MAX_BL_LOG], low};
   assign beat_lat  = lat_q;

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe #(
   parameter int MAX_CL = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       beat,
   input  logic [1:0] lat,
   output logic       rd_valid
);

   if (MAX_CL < 3) begin : g_bad_cl
      $error("sdr_lat_pipe: MAX_CL must be at least 3");
   end

   logic [MAX_CL-1:0] sr, ins;

   // A beat enters the stage from which exactly lat edges reach the output.
   for (genvar i = 0; i < MAX_CL; i++) begin : g_stage
      localparam int unsigned LAT_HERE = MAX_CL - i;
      if (LAT_HERE == 2 || LAT_HERE == 3) begin : g_tap
         assign ins[i] = beat && (lat == 2'(LAT_HERE));
      end else begin : g_none
         assign ins[i] = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr <= '0;
      else        sr <= {sr[MAX_CL-2:0], 1'b0} | ins;
   end

   assign rd_valid = sr[MAX_CL-1];

endmodule

// File: rtl/sdr_modeseq.sv
module sdr_modeseq
   import sdr_modeseq_pkg::*;
#(
   parameter int ADDR_W     = 13,
   parameter int COL_W      = 9,
   parameter int MAX_BL_LOG = 3,
   parameter int MAX_CL     = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cmd,
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   input  logic              banks_idle,
   output logic              col_valid,
   output logic [COL_W-1:0]  col_addr,
   output logic              col_write,
   output logic              rd_valid,
   output logic [1:0]        drive_sel,
   output logic [2:0]        pasr_sel,
   output logic [1:0]        tcsr_sel,
   output logic              cfg_err
);

   if (COL_W > ADDR_W) begin : g_bad_w
      $error("sdr_modeseq: COL_W must not exceed ADDR_W");
   end

   cmd_e       cmd_c;
   mode_t      mode;
   ext_t       ext;
   logic       go, go_wr;
   logic [1:0] blog_eff, beat_lat;

   assign cmd_c    = cmd_e'(cmd);
   assign go       = (cmd_c == CMD_RD) || (cmd_c == CMD_WR);
   assign go_wr    = (cmd_c == CMD_WR);
   assign blog_eff = (go_wr && mode.wr_single) ? 2'd0 : mode.blog;

   sdr_mode_regs #(.ADDR_W(ADDR_W), .MAX_BL_LOG(MAX_BL_LOG)) u_regs (
      .clk(clk), .rst_n(rst_n), .load_en(cmd_c == CMD_LOAD), .ba(ba), .addr(addr),
      .banks_idle(banks_idle), .mode_q(mode), .ext_q(ext), .err_q(cfg_err)
   );

   sdr_burst_gen #(.COL_W(COL_W), .MAX_BL_LOG(MAX_BL_LOG)) u_burst (
      .clk(clk), .rst_n(rst_n), .go(go), .go_wr(go_wr), .go_col(addr[COL_W-1:0]),
      .go_blog(blog_eff), .go_intlv(mode.intlv), .go_lat(mode.lat),
      .col_valid(col_valid), .col_addr(col_addr), .col_write(col_write),
      .beat_lat(beat_lat)
   );

   sdr_lat_pipe #(.MAX_CL(MAX_CL)) u_lat (
      .clk(clk), .rst_n(rst_n), .beat(col_valid && !col_write), .lat(beat_lat),
      .rd_valid(rd_valid)
   );

   assign drive_sel = ext.drive;
   assign pasr_sel  = ext.pasr;
   assign tcsr_sel  = ext.tcsr;

endmodule

// File: rtl/sdr_modeseq_chk.sv
module sdr_modeseq_chk #(
   parameter int ADDR_W = 13,
   parameter int COL_W  = 9
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cmd,
   input logic [1:0]        ba,
   input logic [ADDR_W-1:0] addr,
   input logic              banks_idle,
   input logic              col_valid,
   input logic [COL_W-1:0]  col_addr,
   input logic              col_write,
   input logic              rd_valid,
   input logic [1:0]        drive_sel,
   input logic [2:0]        pasr_sel,
   input logic [1:0]        tcsr_sel,
   input logic              cfg_err
);

   assert_busy_load_flags_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b01 && !banks_idle) |=> cfg_err);

   assert_busy_load_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b01 && !banks_idle) |=> ($stable(drive_sel) && $stable(pasr_sel) && $stable(tcsr_sel)));

   assert_err_needs_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |-> $past(cmd == 2'b01));

   assert_drive_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      drive_sel[1] == 1'b0);

   assert_ext_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b01 && banks_idle && ba == 2'b10 && !addr[6])
      |=> (drive_sel == $past(addr[6:5]) && pasr_sel == $past(addr[2:0]) && tcsr_sel == $past(addr[4:3])));

   assert_first_col_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cmd[1] |=> (col_valid && col_addr == $past(addr[COL_W-1:0]) && col_write == $past(cmd[0])));

   assert_rd_after_beat_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> ($past(col_valid && !col_write, 2) || $past(col_valid && !col_write, 3)));

endmodule

bind sdr_modeseq sdr_modeseq_chk #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .addr(addr), .banks_idle(banks_idle),
   .col_valid(col_valid), .col_addr(col_addr), .col_write(col_write), .rd_valid(rd_valid),
   .drive_sel(drive_sel), .pasr_sel(pasr_sel), .tcsr_sel(tcsr_sel), .cfg_err(cfg_err)
);

// File: tb/sim_sdr_modeseq.sv
module sim_sdr_modeseq;
   localparam int ADDR_W = 13;
   localparam int COL_W  = 9;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        cmd = 2'b00;
   logic [1:0]        ba = 2'b00;
   logic [ADDR_W-1:0] addr = '0;
   logic              banks_idle = 1'b1;
   logic              col_valid, col_write, rd_valid, cfg_err;
   logic [COL_W-1:0]  col_addr;
   logic [1:0]        drive_sel, tcsr_sel;
   logic [2:0]        pasr_sel;

   sdr_modeseq #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .addr(addr), .banks_idle(banks_idle),
      .col_valid(col_valid), .col_addr(col_addr), .col_write(col_write), .rd_valid(rd_valid),
      .drive_sel(drive_sel), .pasr_sel(pasr_sel), .tcsr_sel(tcsr_sel), .cfg_err(cfg_err)
   );

   always #5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   typedef struct { int cyc; int col; bit wr; string req; } col_item_t;
   typedef struct { int bcyc; int vcyc; } rd_item_t;
   col_item_t colq[$];
   rd_item_t  rdq[$];
   int        errq[$];

   // reference model of the configuration
   int m_blog = 0, m_lat = 3, m_drv = 1, m_pasr = 0, m_tcsr = 0;
   bit m_itl = 0, m_ws = 0;

   int compared = 0, mismatched = 0;
   bit mon_en = 0, done = 0;

   task automatic check(bit ok, string req, string what, int act, int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s %s at cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
      end
   endtask

   function automatic int exp_col(int start, int blog, bit itl, int k);
      int len = 1 << blog;
      int lo  = start % len;
      int nl  = itl ? (lo ^ k) : ((lo + k) % len);
      return start - lo + nl;
   endfunction

   function automatic int main_word(int bl, bit itl, int lat, bit ws);
      return bl | (int'(itl) << 3) | (lat << 4) | (int'(ws) << 9);
   endfunction

   function automatic int ext_word(int pasr, int tcsr, int drv);
      return pasr | (tcsr << 3) | (drv << 5);
   endfunction

   // monitor: compares outputs with the scoreboard queues every cycle
   always @(negedge clk) begin
      if (mon_en) begin
         bit ec, er, ee;
         ec = colq.size() > 0 && colq[0].cyc == cyc;
         check(col_valid == ec, ec ? colq[0].req : "R6", "col_valid", col_valid, ec);
         if (ec) begin
            if (col_valid) begin
               check(col_addr == colq[0].col, colq[0].req, "col_addr", col_addr, colq[0].col);
               check(col_write == colq[0].wr, "R6", "col_write", col_write, colq[0].wr);
            end
            void'(colq.pop_front());
         end
         er = rdq.size() > 0 && rdq[0].vcyc == cyc;
         check(rd_valid == er, "R10", "rd_valid", rd_valid, er);
         if (er) void'(rdq.pop_front());
         ee = errq.size() > 0 && errq[0] == cyc;
         check(cfg_err == ee, "R4/R5 cfg_err", "cfg_err", cfg_err, ee);
         if (ee) void'(errq.pop_front());
         check(drive_sel == m_drv, "R3", "drive_sel", drive_sel, m_drv);
         check(pasr_sel == m_pasr, "R3", "pasr_sel", pasr_sel, m_pasr);
         check(tcsr_sel == m_tcsr, "R3", "tcsr_sel", tcsr_sel, m_tcsr);
      end
   end

   // driver: issues one command and pushes what it must produce
   task automatic issue(input logic [1:0] c, input logic [1:0] b, input int a,
                        input bit idle, input string req);
      int now, blog, len;
      bit upd_main = 0, upd_ext = 0;
      @(negedge clk);
      now = cyc;
      cmd = c; ba = b; addr = ADDR_W'(a); banks_idle = idle;
      if (c[1]) begin
         while (colq.size() > 0 && colq[$].cyc >= now + 1) void'(colq.pop_back());
         while (rdq.size() > 0 && rdq[$].bcyc >= now + 1) void'(rdq.pop_back());
         blog = (c[0] && m_ws) ? 0 : m_blog;
         len  = 1 << blog;
         for (int k = 0; k < len; k++) begin
            colq.push_back('{now + 1 + k, exp_col(a % (1 << COL_W), blog, m_itl, k), c[0], req});
            if (!c[0]) rdq.push_back('{now + 1 + k, now + 1 + k + m_lat});
         end
      end else if (c == 2'b01) begin
         int lc = (a >> 4) & 7;
         upd_main = idle && b == 2'b00 && ((a >> 2) & 1) == 0 && (lc == 2 || lc == 3);
         upd_ext  = idle && b == 2'b10 && ((a >> 6) & 1) == 0;
         if (!upd_main && !upd_ext) errq.push_back(now + 1);
      end
      @(posedge clk);
      #1;
      if (upd_main) begin
         m_blog = a & 3; m_itl = (a >> 3) & 1; m_lat = (a >> 4) & 3; m_ws = (a >> 9) & 1;
      end
      if (upd_ext) begin
         m_pasr = a & 7; m_tcsr = (a >> 3) & 3; m_drv = (a >> 5) & 3;
      end
      cmd = 2'b00; banks_idle = 1'b1;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(drive_sel == 2'b01, "R1", "reset drive_sel", drive_sel, 1);
      check(pasr_sel == 0, "R1", "reset pasr_sel", pasr_sel, 0);
      check(tcsr_sel == 0, "R1", "reset tcsr_sel", tcsr_sel, 0);
      check(!col_valid && !rd_valid && !cfg_err, "R1", "reset strobes",
            {col_valid, rd_valid, cfg_err}, 0);
      mon_en = 1;

      // R1: default is one beat, latency 3
      issue(2'b10, 2'b00, 37, 1, "R1");
      idle(8);

      // R2 R7: burst 4 sequential latency 2, wrap inside aligned block
      issue(2'b01, 2'b00, main_word(2, 0, 2, 0), 1, "R2");
      issue(2'b10, 2'b00, 6, 1, "R7");
      idle(8);
      issue(2'b11, 2'b00, 9, 1, "R7");
      idle(8);

      // R8: burst 8 interleaved latency 3
      issue(2'b01, 2'b00, main_word(3, 1, 3, 0), 1, "R2");
      issue(2'b10, 2'b00, 'h1D, 1, "R8");
      idle(14);

      // R7: burst 2 sequential, odd start
      issue(2'b01, 2'b00, main_word(1, 0, 3, 0), 1, "R2");
      issue(2'b10, 2'b00, 'h0FF, 1, "R7");
      idle(8);

      // R9: write-single with burst 8 sequential
      issue(2'b01, 2'b00, main_word(3, 0, 2, 1), 1, "R2");
      issue(2'b11, 2'b00, 'h43, 1, "R9");
      idle(4);
      issue(2'b10, 2'b00, 'h43, 1, "R9");
      idle(14);

      // R4: load while a bank is busy is ignored
      issue(2'b01, 2'b00, main_word(0, 1, 2, 0), 0, "R4");
      issue(2'b01, 2'b10, ext_word(5, 2, 0), 0, "R4");
      issue(2'b10, 2'b00, 'h10, 1, "R4");
      idle(14);

      // R5: reserved codes rejected
      issue(2'b01, 2'b00, main_word(4, 0, 2, 0), 1, "R5");
      issue(2'b01, 2'b00, main_word(1, 0, 1, 0), 1, "R5");
      issue(2'b01, 2'b01, main_word(1, 0, 2, 0), 1, "R5");
      issue(2'b01, 2'b10, ext_word(1, 1, 2), 1, "R5");
      issue(2'b10, 2'b00, 'h21, 1, "R5");
      idle(14);

      // R3: extended register
      issue(2'b01, 2'b10, ext_word(5, 2, 0), 1, "R3");
      idle(2);
      issue(2'b01, 2'b10, ext_word(3, 1, 1), 1, "R3");
      idle(2);

      // R11: interrupt a read with a write, then a read with a read
      issue(2'b01, 2'b00, main_word(3, 0, 3, 0), 1, "R2");
      issue(2'b10, 2'b00, 'h50, 1, "R11");
      idle(2);
      issue(2'b11, 2'b00, 'h88, 1, "R11");
      idle(10);
      issue(2'b10, 2'b00, 'h14, 1, "R11");
      issue(2'b10, 2'b00, 'h2B, 1, "R11");
      idle(16);

      check(colq.size() == 0 && rdq.size() == 0 && errq.size() == 0, "R6", "queues drained",
            colq.size() + rdq.size() + errq.size(), 0);
      done = 1;
      summary();
      $finish;
   end
endmodule